// File: doc/BRIEF.md
# Multi-DAC Output Alignment Sequencer

This block brings the internal FIFOs of one or more DAC devices into line so that their analogue outputs start on the same converter clock. A one-cycle start command launches a fixed sequence. The block drives the shared SYNC pin itself and forces the sample stream headed for the converters to zero for the whole run, so the outputs make no transients. It also hands two configuration-register byte writes to a separate serial-interface master over a request/acknowledge handshake.

The run has five steps. SYNC is taken low and the data is blanked. A write clears the two FIFO-alignment bits of the converter configuration register. SYNC is pulsed high and then low. A second write sets the upper alignment bit and leaves the lower one cleared. Finally, SYNC is raised and left high. The other bits of each written byte come from a parameter default that is held as a shadow value. The register address and both pulse widths are parameters. Busy covers the run, and a one-cycle done marks its end.

Top module: `dac_align_seq`

## Requirements
- R1: While the active-low synchronous reset is asserted, and in the cycle after it, SYNC is low, the zero force is high, and busy, done and the write request are all low.
- R2: A start pulse seen in idle raises busy in the next cycle, with SYNC low and the zero force high. The zero force stays high for as long as busy is high.
- R3: The first write goes to address CFG_ADDR with data equal to CFG_DEFAULT with bit 5 and bit 4 cleared.
- R4: After the first write is acknowledged, SYNC is high for exactly SYNC_HI_CYC cycles and then low for exactly SYNC_LO_CYC cycles before the second request rises. Widths below 4 are raised to 4.
- R5: The second write goes to CFG_ADDR with data equal to CFG_DEFAULT with bit 5 set and bit 4 cleared.
- R6: After the second write is acknowledged, SYNC rises in the next cycle and stays high until another start is accepted or a reset occurs.
- R7: The zero force falls one cycle after that final SYNC rise. In that same cycle done is high for one cycle and busy falls.
- R8: A start pulse that arrives while busy is high has no effect: no extra write, no restart and no extra done.
- R9: A write request stays high with stable data until the acknowledge is seen. Until then the sequence does not advance and SYNC does not change.
- R10: The sample output is zero while the zero force is high and equals the sample input otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle command that begins a run |
| wr_req_o | output | 1 | Register write request to the serial master |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | 8 | Byte to be written |
| wr_ack_i | input | 1 | One-cycle acknowledge from the serial master |
| sync_o | output | 1 | Drive for the shared DAC SYNC pin |
| zero_force_o | output | 1 | High while the sample stream is blanked |
| sample_i | input | DATA_W | Sample stream from the data path |
| sample_o | output | DATA_W | Sample stream towards the serialiser |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run marker |

## Verification
The hardest situation to reach is a stall inside the handshake while a start is also pending. The bench gives its acknowledge responder a different delay in each run, up to twelve cycles, and checks on every cycle of the wait that the request and SYNC hold still. It also pulses start in the middle of a SYNC pulse, where an accepted restart would queue a write the scoreboard does not expect. A reset applied during the pulse shows that the run is dropped and that the idle levels return.

// File: rtl/dac_align_pkg.sv
// Package: shared state encoding and alignment bit positions.
// Assumes the converter configuration register is one byte wide.
package dac_align_pkg;

    localparam int ALIGN_HI_BIT = 5;   // bit set in the second write
    localparam int ALIGN_LO_BIT = 4;   // bit kept clear in both writes
    localparam int CFG_BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PREP  = 3'd1,
        ST_WCLR  = 3'd2,
        ST_PHI   = 3'd3,
        ST_PLO   = 3'd4,
        ST_WSET  = 3'd5,
        ST_SHI   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/dac_align_shadow.sv
// Module: builds the two configuration bytes from a shadow default.
// Assumes the default is a compile-time constant; only the two alignment
// bits differ between the bytes, every other bit copies the default.
module dac_align_shadow
    import dac_align_pkg::*;
#(
    parameter logic [CFG_BYTE_W-1:0] CFG_DEFAULT = 8'hB6
) (
    output logic [CFG_BYTE_W-1:0] clr_byte_o,
    output logic [CFG_BYTE_W-1:0] set_byte_o
);

    for (genvar b = 0; b < CFG_BYTE_W; b++) begin : g_bit
        if (b == ALIGN_HI_BIT) begin : g_hi
            // upper alignment bit: cleared first, then set
            assign clr_byte_o[b] = 1'b0;
            assign set_byte_o[b] = 1'b1;
        end else if (b == ALIGN_LO_BIT) begin : g_lo
            // lower alignment bit: cleared in both writes
            assign clr_byte_o[b] = 1'b0;
            assign set_byte_o[b] = 1'b0;
        end else begin : g_keep
            // untouched bit follows the shadow default
            assign clr_byte_o[b] = CFG_DEFAULT[b];
            assign set_byte_o[b] = CFG_DEFAULT[b];
        end
    end

endmodule

// File: rtl/dac_align_timer.sv
// Module: up-counter that flags the last cycle of a programmable window.
// Assumes limit >= 1 and that clear is held while limit changes.
module dac_align_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt;

    assign expired_o = (cnt == limit_i - 1'b1);

    // count cycles of the window, stop at the last one
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt <= '0;
        end else if (!expired_o) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit_i);

endmodule

// File: rtl/dac_align_wrport.sv
// Module: holds one register write request until the master acknowledges.
// Assumes the acknowledge is a single-cycle pulse given only while a
// request is pending.
module dac_align_wrport
    import dac_align_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_i,
    input  logic [CFG_BYTE_W-1:0] issue_data_i,
    input  logic                  ack_i,
    output logic                  req_o,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [CFG_BYTE_W-1:0] data_o,
    output logic                  acked_o
);

    assign addr_o  = CFG_ADDR;
    assign acked_o = req_o && ack_i;

    // raise the request on issue, drop it when acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            data_o <= '0;
        end else if (issue_i) begin
            req_o  <= 1'b1;
            data_o <= issue_data_i;
        end else if (acked_o) begin
            req_o  <= 1'b0;
        end
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(data_o)));

endmodule

// File: rtl/dac_align_seq.sv
// Module: top of the DAC FIFO alignment sequencer.
// Runs blank -> clear bits -> SYNC pulse -> set bit -> SYNC high.
// Assumes start_i is synchronous to clk; pulse widths are clamped to >= 4.
module dac_align_seq
    import dac_align_pkg::*;
#(
    parameter int                    ADDR_W      = 5,
    parameter logic [ADDR_W-1:0]     CFG_ADDR    = 5'h0A,
    parameter logic [CFG_BYTE_W-1:0] CFG_DEFAULT = 8'hB6,
    parameter int                    DATA_W      = 16,
    parameter int                    SYNC_HI_CYC = 6,
    parameter int                    SYNC_LO_CYC = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    output logic                  wr_req_o,
    output logic [ADDR_W-1:0]     wr_addr_o,
    output logic [CFG_BYTE_W-1:0] wr_data_o,
    input  logic                  wr_ack_i,
    output logic                  sync_o,
    output logic                  zero_force_o,
    input  logic [DATA_W-1:0]     sample_i,
    output logic [DATA_W-1:0]     sample_o,
    output logic                  busy_o,
    output logic                  done_o
);

    localparam int HI_EFF  = (SYNC_HI_CYC < 4) ? 4 : SYNC_HI_CYC;
    localparam int LO_EFF  = (SYNC_LO_CYC < 4) ? 4 : SYNC_LO_CYC;
    localparam int MAX_EFF = (HI_EFF > LO_EFF) ? HI_EFF : LO_EFF;
    localparam int CNT_W   = $clog2(MAX_EFF + 1);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HI_EFF);
    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(LO_EFF);

    seq_state_t            state;
    logic [CFG_BYTE_W-1:0] clr_byte;
    logic [CFG_BYTE_W-1:0] set_byte;
    logic                  issue;
    logic [CFG_BYTE_W-1:0] issue_data;
    logic                  acked;
    logic                  tmr_clear;
    logic [CNT_W-1:0]      tmr_limit;
    logic                  tmr_exp;

    dac_align_shadow #(.CFG_DEFAULT(CFG_DEFAULT)) u_shadow (
        .clr_byte_o (clr_byte),
        .set_byte_o (set_byte)
    );

    dac_align_wrport #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_wrport (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue),
        .issue_data_i (issue_data),
        .ack_i        (wr_ack_i),
        .req_o        (wr_req_o),
        .addr_o       (wr_addr_o),
        .data_o       (wr_data_o),
        .acked_o      (acked)
    );

    dac_align_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .limit_i   (tmr_limit),
        .expired_o (tmr_exp)
    );

    // pick the timer window and restart it outside or at the end of a window
    always_comb begin
        tmr_limit = (state == ST_PLO) ? LO_LIM : HI_LIM;
        tmr_clear = !((state == ST_PHI) || (state == ST_PLO))
                    || ((state == ST_PHI) && tmr_exp);
    end

    // decide when a register write is launched and with which byte
    always_comb begin
        issue      = 1'b0;
        issue_data = clr_byte;
        if (state == ST_PREP) begin
            issue      = 1'b1;
            issue_data = clr_byte;
        end else if ((state == ST_PLO) && tmr_exp) begin
            issue      = 1'b1;
            issue_data = set_byte;
        end
    end

    // sequence state and registered pin drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            sync_o       <= 1'b0;
            zero_force_o <= 1'b1;
            busy_o       <= 1'b0;
            done_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    state        <= ST_PREP;
                    busy_o       <= 1'b1;
                    sync_o       <= 1'b0;
                    zero_force_o <= 1'b1;
                end
                ST_PREP: state <= ST_WCLR;
                ST_WCLR: if (acked) begin
                    state  <= ST_PHI;
                    sync_o <= 1'b1;
                end
                ST_PHI: if (tmr_exp) begin
                    state  <= ST_PLO;
                    sync_o <= 1'b0;
                end
                ST_PLO: if (tmr_exp) state <= ST_WSET;
                ST_WSET: if (acked) begin
                    state  <= ST_SHI;
                    sync_o <= 1'b1;
                end
                ST_SHI: begin
                    state        <= ST_IDLE;
                    zero_force_o <= 1'b0;
                    busy_o       <= 1'b0;
                    done_o       <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sample_o = zero_force_o ? '0 : sample_i;

    assert_force_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> zero_force_o);

    assert_start_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!sync_o && zero_force_o && !wr_req_o));

    assert_bit4_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !wr_data_o[ALIGN_LO_BIT]);

    assert_second_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && (state == ST_WSET)) |-> wr_data_o[ALIGN_HI_BIT]);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_release_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zero_force_o) |-> (done_o && sync_o && $past(sync_o) && !busy_o));

    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && !busy_o) |=> (sync_o || busy_o));

    assert_wait_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> $stable(sync_o));

endmodule

// File: tb/tb_dac_align_seq.sv
// Bench: scoreboard of expected register writes plus cycle monitors.
module tb_dac_align_seq;

    localparam int CLK_P = 10;
    localparam int AW    = 5;
    localparam int DW    = 16;
    localparam int HI    = 6;
    localparam int LO    = 5;
    localparam logic [AW-1:0] ADDR = 5'h0A;
    localparam logic [7:0]    DEF  = 8'hB6;
    localparam logic [7:0]    EXP_CLR = DEF & ~8'h30;
    localparam logic [7:0]    EXP_SET = (DEF & ~8'h30) | 8'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic wr_ack_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic wr_req_o, sync_o, zero_force_o, busy_o, done_o;
    logic [AW-1:0] wr_addr_o;
    logic [7:0] wr_data_o;
    logic [DW-1:0] sample_o;

    dac_align_seq #(
        .ADDR_W(AW), .CFG_ADDR(ADDR), .CFG_DEFAULT(DEF), .DATA_W(DW),
        .SYNC_HI_CYC(HI), .SYNC_LO_CYC(LO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ack_i(wr_ack_i), .sync_o(sync_o), .zero_force_o(zero_force_o),
        .sample_i(sample_i), .sample_o(sample_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ack_delay = 1;
    int done_seen = 0;
    int done_expected = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [7:0]    data;
        string         tag;
    } wr_item_t;
    wr_item_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    // fresh sample data on every cycle
    always @(negedge clk) sample_i <= DW'($urandom);

    // serial master model: waits, checks the held request, pops scoreboard, acks
    initial begin
        logic s0;
        wr_item_t e;
        forever begin
            @(negedge clk);
            if (rst_n && wr_req_o) begin
                s0 = sync_o;
                for (int i = 0; i < ack_delay; i++) begin
                    @(negedge clk);
                    chk(wr_req_o == 1'b1, "R9 request held", wr_req_o, 1);
                    chk(sync_o == s0, "R9 sync frozen during wait", sync_o, s0);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected write", wr_data_o, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(wr_addr_o == e.addr, {e.tag, " address"}, wr_addr_o, e.addr);
                    chk(wr_data_o == e.data, {e.tag, " data"}, wr_data_o, e.data);
                end
                wr_ack_i = 1'b1;
                @(negedge clk);
                wr_ack_i = 1'b0;
            end
        end
    end

    // cycle monitor: pulse widths, data blanking, end-of-run ordering
    logic prev_sync = 1'b0, prev_force = 1'b1, prev_done = 1'b0, prev_busy = 1'b0;
    int   hi_cnt = 0, lo_cnt = 0;
    bit   pulse_done = 0, lo_checked = 0, after_done = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            hi_cnt = 0; lo_cnt = 0; pulse_done = 0; lo_checked = 0; after_done = 0;
            prev_sync = 1'b0; prev_force = 1'b1; prev_done = 1'b0; prev_busy = 1'b0;
        end else begin
            chk(sample_o == (zero_force_o ? '0 : sample_i), "R10 sample path",
                sample_o, zero_force_o ? 0 : sample_i);
            if (busy_o) chk(zero_force_o == 1'b1, "R2 force while busy", zero_force_o, 1);
            if (busy_o && !prev_busy) begin
                chk(!sync_o && zero_force_o, "R2 start levels", {sync_o, zero_force_o}, 2'b01);
                hi_cnt = 0; lo_cnt = 0; pulse_done = 0; lo_checked = 0; after_done = 0;
            end
            if (busy_o && !pulse_done) begin
                if (sync_o) hi_cnt++;
                else if (hi_cnt > 0) begin
                    pulse_done = 1;
                    chk(hi_cnt == HI, "R4 pulse high width", hi_cnt, HI);
                    lo_cnt = 1;
                end
            end else if (busy_o && pulse_done && !lo_checked) begin
                if (!wr_req_o && !sync_o) lo_cnt++;
                else begin
                    chk(lo_cnt == LO, "R4 pulse low width", lo_cnt, LO);
                    lo_checked = 1;
                end
            end
            if (done_o) begin
                done_seen++;
                chk(prev_sync && prev_force, "R7 sync high one cycle before release",
                    {prev_sync, prev_force}, 2'b11);
                chk(!busy_o && !zero_force_o, "R7 busy and force drop with done",
                    {busy_o, zero_force_o}, 2'b00);
                after_done = 1;
            end
            if (prev_done) chk(!done_o, "R7 done single cycle", done_o, 0);
            if (after_done && !busy_o) chk(sync_o, "R6 sync held high", sync_o, 1);
            prev_sync = sync_o; prev_force = zero_force_o;
            prev_done = done_o; prev_busy = busy_o;
        end
    end

    // driver: push the expected writes, pulse start, optionally poke start mid-run
    task automatic run_seq(input int dly, input bit poke);
        wr_item_t a, b;
        ack_delay = dly;
        a.addr = ADDR; a.data = EXP_CLR; a.tag = "R3 first write";
        b.addr = ADDR; b.data = EXP_SET; b.tag = "R5 second write";
        exp_q.push_back(a);
        exp_q.push_back(b);
        done_expected++;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (poke) begin
            while (!(busy_o && sync_o)) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 R5 all writes issued", exp_q.size(), 0);
    endtask

    task automatic check_reset_state(input string tag);
        chk(!sync_o, {tag, " sync"}, sync_o, 0);
        chk(zero_force_o, {tag, " force"}, zero_force_o, 1);
        chk(!busy_o && !done_o && !wr_req_o, {tag, " busy/done/req"},
            {busy_o, done_o, wr_req_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 after release");

        run_seq(1, 1'b0);
        repeat (10) @(negedge clk);
        chk(sample_o == sample_i, "R10 pass-through after run", sample_o, sample_i);

        run_seq(5, 1'b0);
        run_seq(2, 1'b1);
        repeat (20) @(negedge clk);
        chk(done_seen == done_expected, "R8 no extra run from start while busy",
            done_seen, done_expected);
        chk(!busy_o, "R8 idle after ignored start", busy_o, 0);

        // reset during the SYNC pulse
        exp_q.push_back('{ADDR, EXP_CLR, "R3 first write"});
        ack_delay = 1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!(busy_o && sync_o)) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 mid-run reset");
        exp_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 after mid-run reset");

        run_seq(12, 1'b0);
        chk(done_seen == done_expected, "R7 done count", done_seen, done_expected);
        finish_run();
    end

endmodule